// File: doc/BRIEF.md
# Trigger-Positioned Trace Capture Buffer

This block records a stream of valid-qualified trace words into an on-chip memory and keeps one window of them, placed around a trigger pulse. Once armed, it stores every accepted word in a circular memory that overwrites its oldest entries while it waits for the trigger. A placement select sets how many accepted words are still stored after the trigger. The trigger can land at the end of the kept window (no words after it), at its start (a full memory of words from the trigger on) or in its middle (half a memory after it). When that count is reached, writes freeze and a done flag rises.

A stop-when-full option ends capture the first time the memory fills, whatever the trigger is doing. The write pointer at the trigger is held on an output. The kept words are drained through a read port indexed by logical position: index 0 is always the oldest kept word, and later indices follow in time order.

Top module: `trace_window_capture`

## Requirements
- R1: While reset is high and on the first cycle after it, done is 0, trig_addr is 0 and kept_count is 0.
- R2: After arm and before the trigger, every word with in_valid high is stored at the current write slot, the slot advances by one modulo DEPTH, and kept_count grows up to DEPTH and then stays at DEPTH while the oldest entries are overwritten.
- R3: With pos_mode = 2'b00 (trigger at end), a trigger raises done on the next cycle, the word presented in the trigger cycle is not stored, and the kept window is the last DEPTH (or fewer) words before the trigger.
- R4: With pos_mode = 2'b01 (trigger at start), the trigger-cycle word and the words after it are stored until DEPTH words have been stored from the trigger on, then done rises; index 0 of the readout is the trigger-cycle word.
- R5: With pos_mode = 2'b10 (trigger in middle), DEPTH/2 words are stored from the trigger-cycle word on, then done rises; on a full window the trigger-cycle word sits at readout index DEPTH/2.
- R6: With stop_on_full high, done rises the cycle after the write that fills the last slot for the first time since arm, whether or not a trigger has occurred.
- R7: Only the first trigger after arm is taken; later trigger pulses before the next arm leave trig_addr and the capture unchanged.
- R8: While done is high, in_valid has no effect: kept_count and the stored words stay unchanged.
- R9: trig_addr holds the write slot that was current in the trigger cycle (the slot where the trigger-cycle word goes), and 0 if no trigger was taken.
- R10: rd_data, one cycle after rd_en with index rd_idx, is the word at logical position rd_idx counted from the oldest kept word. The oldest word is at the write slot if the memory has wrapped, and at slot 0 otherwise.
- R11: A pulse on arm clears done, kept_count and trig_addr on the next cycle and starts a new capture at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Start a new capture (pulse) |
| pos_mode | input | 2 | Trigger placement: 00 end, 01 start, 10 middle, 11 as end |
| stop_on_full | input | 1 | End capture the first time the memory fills |
| in_valid | input | 1 | Trace word qualifier |
| in_data | input | DATA_W | Trace word |
| trig | input | 1 | Trigger pulse |
| rd_en | input | 1 | Read request |
| rd_idx | input | $clog2(DEPTH) | Logical read index, 0 = oldest |
| done | output | 1 | Capture finished, writes frozen |
| trig_addr | output | $clog2(DEPTH) | Write slot at the trigger |
| kept_count | output | $clog2(DEPTH)+1 | Number of valid stored words |
| rd_valid | output | 1 | rd_data is valid |
| rd_data | output | DATA_W | Word read out |

## Verification
The bench builds the block with DEPTH = 8 and DATA_W = 16. The short depth lets a handful of words wrap the memory, fill it for the first time, and place the middle trigger at index 4, all within a few dozen cycles per case. Sixteen-bit words let each stored word carry its own sequence number, so a readout shows directly which words survived the window and in what order.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_POST = 2'd2,
    ST_DONE = 2'd3
  } tw_state_t;

  localparam logic [1:0] POS_END   = 2'd0;
  localparam logic [1:0] POS_START = 2'd1;
  localparam logic [1:0] POS_MID   = 2'd2;
endpackage

// File: rtl/tw_store.sv
module tw_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) rvalid <= 1'b0;
    else     rvalid <= re;
  end

  assert_read_latency_R10: assert property (@(posedge clk) disable iff (rst)
    re |=> rvalid);
endmodule

// File: rtl/tw_rdaddr.sv
module tw_rdaddr #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic [AW-1:0] wptr,
  input  logic          wrapped,
  input  logic [AW-1:0] rd_idx,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   kept
);
  logic [AW-1:0] oldest;

  always_comb begin
    oldest = wrapped ? wptr : '0;
    raddr  = oldest + rd_idx;
    kept   = wrapped ? (AW+1)'(DEPTH) : {1'b0, wptr};
  end
endmodule

// File: rtl/tw_ctrl.sv
module tw_ctrl
  import tw_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic [1:0]    pos_mode,
  input  logic          stop_on_full,
  input  logic          in_valid,
  input  logic          trig,
  output logic          we,
  output logic [AW-1:0] wptr,
  output logic          wrapped,
  output logic [AW-1:0] trig_addr,
  output logic          done
);
  tw_state_t st, st_nxt;
  logic [CW-1:0] cnt, tgt_q, tgt_now;
  logic          fill_now;

  always_comb begin
    case (pos_mode)
      POS_START: tgt_now = CW'(DEPTH);
      POS_MID:   tgt_now = CW'(DEPTH / 2);
      default:   tgt_now = '0;
    endcase
  end

  always_comb begin
    we = 1'b0;
    if (!arm) begin
      if (st == ST_POST) we = in_valid;
      else if (st == ST_PRE) we = in_valid && !(trig && tgt_now == '0);
    end
    fill_now = we && !wrapped && (wptr == AW'(DEPTH - 1));
  end

  always_comb begin
    st_nxt = st;
    case (st)
      ST_PRE: begin
        if (trig) begin
          if (tgt_now == '0)                      st_nxt = ST_DONE;
          else if (we && tgt_now == CW'(1))       st_nxt = ST_DONE;
          else                                    st_nxt = ST_POST;
        end
      end
      ST_POST: if (we && (cnt + CW'(1)) == tgt_q) st_nxt = ST_DONE;
      default: ;
    endcase
    if (stop_on_full && fill_now) st_nxt = ST_DONE;
    if (arm) st_nxt = ST_PRE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      done      <= 1'b0;
      wptr      <= '0;
      wrapped   <= 1'b0;
      trig_addr <= '0;
      cnt       <= '0;
      tgt_q     <= '0;
    end else begin
      st   <= st_nxt;
      done <= (st_nxt == ST_DONE);
      if (arm) begin
        wptr      <= '0;
        wrapped   <= 1'b0;
        trig_addr <= '0;
        cnt       <= '0;
        tgt_q     <= '0;
      end else begin
        if (we) begin
          wptr <= wptr + AW'(1);
          if (wptr == AW'(DEPTH - 1)) wrapped <= 1'b1;
        end
        if (st == ST_PRE && trig) begin
          trig_addr <= wptr;
          tgt_q     <= tgt_now;
          cnt       <= we ? CW'(1) : '0;
        end else if (st == ST_POST && we) begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!done && wptr == '0 && !wrapped && trig_addr == '0));

  assert_pre_advance_R2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PRE && in_valid && !trig && !arm) |=> (wptr == $past(wptr) + AW'(1)));

  assert_end_done_R3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PRE && trig && pos_mode == POS_END && !arm) |=> done);

  assert_full_stop_R6: assert property (@(posedge clk) disable iff (rst)
    (stop_on_full && fill_now && !arm) |=> done);

  assert_trig_hold_R7: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_POST || st == ST_DONE) && !arm) |=> $stable(trig_addr));

  assert_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (done && !arm) |=> ($stable(wptr) && $stable(wrapped)));

  assert_rearm_R11: assert property (@(posedge clk) disable iff (rst)
    arm |=> (!done && wptr == '0 && !wrapped));
endmodule

// File: rtl/trace_window_capture.sv
module trace_window_capture #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic [1:0]        pos_mode,
  input  logic              stop_on_full,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              trig,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_idx,
  output logic              done,
  output logic [AW-1:0]     trig_addr,
  output logic [AW:0]       kept_count,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic          we;
  logic [AW-1:0] wptr;
  logic          wrapped;
  logic [AW-1:0] raddr;

  tw_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .arm          (arm),
    .pos_mode     (pos_mode),
    .stop_on_full (stop_on_full),
    .in_valid     (in_valid),
    .trig         (trig),
    .we           (we),
    .wptr         (wptr),
    .wrapped      (wrapped),
    .trig_addr    (trig_addr),
    .done         (done)
  );

  tw_rdaddr #(.DEPTH(DEPTH)) u_rdaddr (
    .wptr    (wptr),
    .wrapped (wrapped),
    .rd_idx  (rd_idx),
    .raddr   (raddr),
    .kept    (kept_count)
  );

  tw_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk    (clk),
    .rst    (rst),
    .we     (we),
    .waddr  (wptr),
    .wdata  (in_data),
    .re     (rd_en),
    .raddr  (raddr),
    .rdata  (rd_data),
    .rvalid (rd_valid)
  );

  assert_kept_bound_R2: assert property (@(posedge clk) disable iff (rst)
    kept_count <= (AW+1)'(DEPTH));
endmodule

// File: tb/trace_window_capture_test.sv
module trace_window_capture_test;
  localparam int DW = 16;
  localparam int DP = 8;
  localparam int AW = $clog2(DP);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic arm = 1'b0;
  logic [1:0] pos_mode = 2'd0;
  logic stop_on_full = 1'b0;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic trig = 1'b0;
  logic rd_en = 1'b0;
  logic [AW-1:0] rd_idx = '0;
  logic done;
  logic [AW-1:0] trig_addr;
  logic [AW:0] kept_count;
  logic rd_valid;
  logic [DW-1:0] rd_data;

  always #2.5 clk = ~clk;

  trace_window_capture #(.DATA_W(DW), .DEPTH(DP)) uut (
    .clk(clk), .rst(rst), .arm(arm), .pos_mode(pos_mode),
    .stop_on_full(stop_on_full), .in_valid(in_valid), .in_data(in_data),
    .trig(trig), .rd_en(rd_en), .rd_idx(rd_idx), .done(done),
    .trig_addr(trig_addr), .kept_count(kept_count), .rd_valid(rd_valid),
    .rd_data(rd_data)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic        sof;
    logic [7:0]  p;
    logic [7:0]  e;
    logic        dn;
    logic [7:0]  ta;
    logic [7:0]  kp;
    logic [15:0] first;
    logic [15:0] last;
  } vec_t;

  // mode, stop_on_full, pre words, post words, done, trig_addr, kept, first, last
  localparam vec_t VECS [8] = '{
    '{2'd0, 1'b0, 8'd11, 8'd3,  1'b1, 8'd3, 8'd8, 16'd4, 16'd11},
    '{2'd0, 1'b0, 8'd5,  8'd3,  1'b1, 8'd5, 8'd5, 16'd1, 16'd5},
    '{2'd1, 1'b0, 8'd3,  8'd10, 1'b1, 8'd3, 8'd8, 16'd4, 16'd11},
    '{2'd1, 1'b0, 8'd2,  8'd3,  1'b0, 8'd2, 8'd6, 16'd1, 16'd6},
    '{2'd2, 1'b0, 8'd9,  8'd6,  1'b1, 8'd1, 8'd8, 16'd6, 16'd13},
    '{2'd2, 1'b0, 8'd1,  8'd5,  1'b1, 8'd1, 8'd5, 16'd1, 16'd5},
    '{2'd1, 1'b1, 8'd10, 8'd0,  1'b1, 8'd0, 8'd8, 16'd1, 16'd8},
    '{2'd1, 1'b1, 8'd2,  8'd10, 1'b1, 8'd2, 8'd8, 16'd1, 16'd8}
  };

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [DW-1:0] rv;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic put_word(input logic [DW-1:0] d, input logic t);
    in_valid = 1'b1; in_data = d; trig = t;
    tick();
    in_valid = 1'b0; trig = 1'b0;
  endtask

  task automatic do_arm(input logic [1:0] m, input logic s);
    pos_mode = m; stop_on_full = s; arm = 1'b1;
    tick();
    arm = 1'b0;
  endtask

  task automatic read_at(input int i, output logic [DW-1:0] d);
    rd_en = 1'b1; rd_idx = AW'(i);
    tick();
    rd_en = 1'b0;
    d = rd_data;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 50000);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    // R1: reset state
    check("R1 done", done, 0);
    check("R1 trig_addr", trig_addr, 0);
    check("R1 kept", kept_count, 0);
    rst = 1'b0;
    tick();
    check("R1 done after release", done, 0);

    // Vector table: R2 R3 R4 R5 R6 R8 R9 R10
    for (int v = 0; v < 8; v++) begin
      vec_t c;
      c = VECS[v];
      do_arm(c.mode, c.sof);
      for (int i = 1; i <= int'(c.p); i++) begin
        put_word(DW'(i), 1'b0);
        if (i % 3 == 0) tick();
      end
      put_word(DW'(c.p + 1), 1'b1);
      for (int j = 0; j < int'(c.e); j++) begin
        put_word(DW'(c.p + 2 + j), 1'b0);
        if (j % 4 == 1) tick();
      end
      tick();
      check($sformatf("R3/R4/R5/R6 done vec%0d", v), done, c.dn);
      check($sformatf("R9 trig_addr vec%0d", v), trig_addr, c.ta);
      check($sformatf("R2/R8 kept vec%0d", v), kept_count, c.kp);
      read_at(0, rv);
      check($sformatf("R10 first vec%0d", v), rv, c.first);
      read_at(int'(c.kp) - 1, rv);
      check($sformatf("R10 last vec%0d", v), rv, c.last);
    end

    // R5: trigger word sits at index DEPTH/2 on a full middle window
    do_arm(2'd2, 1'b0);
    for (int i = 1; i <= 9; i++) put_word(DW'(100 + i), i == 6);
    tick();
    check("R5 done", done, 1);
    read_at(DP / 2, rv);
    check("R5 trigger word at middle", rv, 106);

    // R7: second trigger ignored
    do_arm(2'd1, 1'b0);
    put_word(16'd1, 1'b0);
    put_word(16'd2, 1'b0);
    put_word(16'd3, 1'b1);
    put_word(16'd4, 1'b0);
    put_word(16'd5, 1'b1);
    put_word(16'd6, 1'b0);
    tick();
    check("R7 trig_addr kept", trig_addr, 2);
    check("R7 still capturing", done, 0);
    check("R7 kept", kept_count, 6);

    // R8: words after done have no effect
    do_arm(2'd0, 1'b0);
    put_word(16'd50, 1'b0);
    put_word(16'd51, 1'b1);
    put_word(16'd52, 1'b0);
    put_word(16'd53, 1'b0);
    tick();
    check("R8 kept frozen", kept_count, 1);
    read_at(0, rv);
    check("R8 word frozen", rv, 50);

    // R11: re-arm clears
    do_arm(2'd0, 1'b0);
    check("R11 done cleared", done, 0);
    check("R11 kept cleared", kept_count, 0);
    check("R11 trig_addr cleared", trig_addr, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule